// File: doc/BRIEF.md
# Partial-Bypass Scoreboard Interlock

This block sits at the operand-read stage of a five-stage in-order pipeline (fetch, decode, operand read, execute, writeback). It decides, for every source operand of the instruction waiting in operand read, whether the value can come from the register file or from the execute-stage forwarding path. When neither source can supply a value in time, it raises a stall. Forwarding from execute is wired per operand slot, so a dependency that is harmless on one slot can stall on another. A set of static configuration bits describes which slots have that path, so one netlist serves every partial configuration.

The unit keeps its own register scoreboard and the tags of the execute and writeback stages. An instruction that issues with a nonzero destination marks that register busy. The mark is cleared when the write reaches the register file two cycles later. The register file writes before it reads, so a register being written back is readable in the same cycle. A stall holds decode and operand read, and places a bubble in execute. The surrounding pipeline is expected to present the same operand-read contents again after a stalled cycle.

Top module: `partial_bypass_interlock`

## Requirements
- R1: After reset no register is busy, `stall`, `exLive` and `wbWrite` are 0, and with `orValid` low `stall` stays 0.
- R2: If a used source names the register whose producer is in execute, and that slot's bit in `cfgExBypass` is 0, `stall` is 1 for exactly one cycle. In the next cycle the held instruction issues and that slot reads the register file (`opSel` bit 0).
- R3: The same dependency on a slot whose `cfgExBypass` bit is 1 raises no stall, and that slot's `opSel` bit is 1 (execute bypass).
- R4: A source naming the register being written back in the current cycle raises no stall and selects the register file (0).
- R5: Register 0 is never busy. A source of 0 never stalls, and a write to register 0 never produces `wbWrite`.
- R6: An instruction whose destination is busy with its producer in execute stalls (write-after-write). If the busy producer is in writeback in that cycle, it issues without a stall and the register stays tracked for the new write.
- R7: A stalled cycle leaves execute empty in the next cycle (`exLive` 0). An issued instruction makes `exLive` 1 in the next cycle.
- R8: An instruction issued with write enable and nonzero destination in cycle t shows `wbWrite` 1 with `wbReg` equal to its destination in cycle t+2.
- R9: Each `opSel` bit can be 1 only when its `cfgExBypass` bit is 1. With all bits set, a dependency on every slot is bypassed. With all bits clear, any execute dependency stalls.
- R10: A source whose `orSrcUse` bit is 0 never causes a stall and selects the register file.
- R11: With `orValid` low nothing issues and `stall` is 0, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgExBypass | input | NUM_OPS | Static per-slot execute-bypass presence, bit k for slot k |
| orValid | input | 1 | An instruction occupies operand read |
| orSrc | input | NUM_OPS x REG_W | Source register numbers, slot k in element k |
| orSrcUse | input | NUM_OPS | Slot k actually reads its source |
| orDest | input | REG_W | Destination register number |
| orDestWe | input | 1 | The instruction writes its destination |
| stall | output | 1 | Hold decode and operand read, bubble into execute |
| opSel | output | NUM_OPS | Per slot: 1 take execute bypass, 0 take register file |
| exLive | output | 1 | Execute holds an issued instruction |
| wbWrite | output | 1 | Register file write this cycle |
| wbReg | output | REG_W | Register written this cycle |

## Verification
Two functions can fall in the same cycle: a writeback that clears a scoreboard entry and an issue that reads or re-marks that same register. The bench provokes this in three ways. A consumer is placed one cycle behind an unrelated instruction, so its producer reaches writeback just as it reads. A write-after-write pair is released on the cycle its first write retires. A stalled consumer retries as its producer retires. In each case the expected result is no stall with a register-file select, or a second `wbWrite` for the re-marked register two cycles later. That second write proves the set took priority over the clear.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  typedef enum logic {
    SEL_RF = 1'b0,
    SEL_EX = 1'b1
  } srcSel_e;

  typedef struct packed {
    logic issue;
    logic issueWrite;
  } ctlStrobe_t;

endpackage

// File: rtl/bypass_operand_lane.sv
module bypass_operand_lane
  import bypass_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic [REG_W-1:0] src,
  input  logic             srcUse,
  input  logic             bypassEn,
  input  logic [NREG-1:0]  busy,
  input  logic             exValid,
  input  logic [REG_W-1:0] exTag,
  input  logic             wbValid,
  input  logic [REG_W-1:0] wbTag,
  output srcSel_e          sel,
  output logic             hazard
);

  logic needsValue;
  logic inRegFile;
  logic inExecute;
  logic bypassOk;

  always_comb begin
    needsValue = srcUse && (src != '0);
    inRegFile  = !busy[src] || (wbValid && (wbTag == src));
    inExecute  = exValid && (exTag == src);
    bypassOk   = inExecute && bypassEn;
    hazard     = needsValue && !inRegFile && !bypassOk;
    sel        = (needsValue && !inRegFile && bypassOk) ? SEL_EX : SEL_RF;
  end

endmodule

// File: rtl/bypass_interlock_ctl.sv
module bypass_interlock_ctl
  import bypass_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int REG_W   = 5,
  localparam int NREG   = 1 << REG_W
) (
  input  logic                          orValid,
  input  logic [NUM_OPS-1:0][REG_W-1:0] orSrc,
  input  logic [NUM_OPS-1:0]            orSrcUse,
  input  logic [REG_W-1:0]              orDest,
  input  logic                          orDestWe,
  input  logic [NUM_OPS-1:0]            cfgExBypass,
  input  logic [NREG-1:0]               busy,
  input  logic                          exValid,
  input  logic [REG_W-1:0]              exTag,
  input  logic                          wbValid,
  input  logic [REG_W-1:0]              wbTag,
  output ctlStrobe_t                    strobe,
  output logic                          stall,
  output logic [NUM_OPS-1:0]            opSel
);

  logic [NUM_OPS-1:0] laneHazard;
  logic               destWrites;
  logic               wawHazard;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_lane
    srcSel_e laneSel;

    bypass_operand_lane #(.REG_W(REG_W)) u_lane (
      .src      (orSrc[k]),
      .srcUse   (orSrcUse[k]),
      .bypassEn (cfgExBypass[k]),
      .busy     (busy),
      .exValid  (exValid),
      .exTag    (exTag),
      .wbValid  (wbValid),
      .wbTag    (wbTag),
      .sel      (laneSel),
      .hazard   (laneHazard[k])
    );

    assign opSel[k] = (laneSel == SEL_EX);
  end

  always_comb begin
    destWrites        = orDestWe && (orDest != '0);
    wawHazard         = destWrites && busy[orDest] && !(wbValid && (wbTag == orDest));
    stall             = orValid && ((|laneHazard) || wawHazard);
    strobe.issue      = orValid && !stall;
    strobe.issueWrite = orValid && !stall && destWrites;
  end

endmodule

// File: rtl/bypass_sb_datapath.sv
module bypass_sb_datapath
  import bypass_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [REG_W-1:0] orDest,
  output logic [NREG-1:0]  busy,
  output logic             exLive,
  output logic             exValid,
  output logic [REG_W-1:0] exTag,
  output logic             wbValid,
  output logic [REG_W-1:0] wbTag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exLive  <= 1'b0;
      exValid <= 1'b0;
      exTag   <= '0;
      wbValid <= 1'b0;
      wbTag   <= '0;
    end else begin
      exLive  <= strobe.issue;
      exValid <= strobe.issueWrite;
      exTag   <= strobe.issueWrite ? orDest : '0;
      wbValid <= exValid;
      wbTag   <= exTag;
    end
  end

  // Clear on retirement first, then set on issue, so a same-cycle
  // re-mark of the retiring register survives.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
    end else begin
      if (wbValid) busy[wbTag] <= 1'b0;
      if (strobe.issueWrite) busy[orDest] <= 1'b1;
    end
  end

endmodule

// File: rtl/partial_bypass_interlock.sv
module partial_bypass_interlock
  import bypass_pkg::*;
#(
  parameter int NUM_OPS = 2,
  parameter int REG_W   = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_OPS-1:0]            cfgExBypass,
  input  logic                          orValid,
  input  logic [NUM_OPS-1:0][REG_W-1:0] orSrc,
  input  logic [NUM_OPS-1:0]            orSrcUse,
  input  logic [REG_W-1:0]              orDest,
  input  logic                          orDestWe,
  output logic                          stall,
  output logic [NUM_OPS-1:0]            opSel,
  output logic                          exLive,
  output logic                          wbWrite,
  output logic [REG_W-1:0]              wbReg
);

  localparam int NREG = 1 << REG_W;

  ctlStrobe_t       strobe;
  logic [NREG-1:0]  busy;
  logic             exValid;
  logic [REG_W-1:0] exTag;
  logic             wbValid;
  logic [REG_W-1:0] wbTag;

  bypass_interlock_ctl #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) u_ctl (
    .orValid     (orValid),
    .orSrc       (orSrc),
    .orSrcUse    (orSrcUse),
    .orDest      (orDest),
    .orDestWe    (orDestWe),
    .cfgExBypass (cfgExBypass),
    .busy        (busy),
    .exValid     (exValid),
    .exTag       (exTag),
    .wbValid     (wbValid),
    .wbTag       (wbTag),
    .strobe      (strobe),
    .stall       (stall),
    .opSel       (opSel)
  );

  bypass_sb_datapath #(.REG_W(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .orDest  (orDest),
    .busy    (busy),
    .exLive  (exLive),
    .exValid (exValid),
    .exTag   (exTag),
    .wbValid (wbValid),
    .wbTag   (wbTag)
  );

  assign wbWrite = wbValid;
  assign wbReg   = wbTag;

endmodule

// File: rtl/partial_bypass_interlock_chk.sv
module partial_bypass_interlock_chk #(
  parameter int NUM_OPS = 2,
  parameter int REG_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_OPS-1:0] cfgExBypass,
  input logic               orValid,
  input logic [REG_W-1:0]   orDest,
  input logic               orDestWe,
  input logic               stall,
  input logic [NUM_OPS-1:0] opSel,
  input logic               exLive,
  input logic               wbWrite,
  input logic [REG_W-1:0]   wbReg
);

  // R2: the hazard window is a single cycle
  assert_stall_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  // R7: a stalled cycle puts a bubble into execute
  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !exLive);

  // R11: nothing to issue, nothing to stall
  assert_idle_no_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    !orValid |-> !stall);

  // R5: register 0 is never written back
  assert_no_r0_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wbWrite |-> (wbReg != '0));

  // R8: write reaches the register file two cycles after issue
  assert_wb_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (orValid && !stall && orDestWe && (orDest != '0)) |=> ##1 (wbWrite && (wbReg == $past(orDest, 2))));

  // R9: a slot selects the bypass only if that slot has one
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_sel
    assert_sel_cfg_R9: assert property (@(posedge clk) disable iff (!rstN)
      opSel[k] |-> cfgExBypass[k]);
  end

endmodule

bind partial_bypass_interlock partial_bypass_interlock_chk #(
  .NUM_OPS(NUM_OPS),
  .REG_W  (REG_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgExBypass (cfgExBypass),
  .orValid     (orValid),
  .orDest      (orDest),
  .orDestWe    (orDestWe),
  .stall       (stall),
  .opSel       (opSel),
  .exLive      (exLive),
  .wbWrite     (wbWrite),
  .wbReg       (wbReg)
);

// File: tb/sim_partial_bypass_interlock.sv
`timescale 1ns/1ps
module sim_partial_bypass_interlock;

  localparam int NUM_OPS = 2;
  localparam int REG_W   = 5;
  localparam int MAX_CYC = 5000;

  logic                          clk = 1'b0;
  logic                          rstN = 1'b0;
  logic [NUM_OPS-1:0]            cfgExBypass = 2'b10;
  logic                          orValid = 1'b0;
  logic [NUM_OPS-1:0][REG_W-1:0] orSrc = '0;
  logic [NUM_OPS-1:0]            orSrcUse = '0;
  logic [REG_W-1:0]              orDest = '0;
  logic                          orDestWe = 1'b0;
  logic                          stall;
  logic [NUM_OPS-1:0]            opSel;
  logic                          exLive;
  logic                          wbWrite;
  logic [REG_W-1:0]              wbReg;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    int    s;
    int    sa;
    int    sb;
    int    ex;
    int    wb;
    int    wr;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  partial_bypass_interlock #(.NUM_OPS(NUM_OPS), .REG_W(REG_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgExBypass(cfgExBypass), .orValid(orValid),
    .orSrc(orSrc), .orSrcUse(orSrcUse), .orDest(orDest), .orDestWe(orDestWe),
    .stall(stall), .opSel(opSel), .exLive(exLive), .wbWrite(wbWrite), .wbReg(wbReg)
  );

  task automatic chk(string req, string what, int act, int exp);
    if (exp >= 0) begin
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
    end
  endtask

  // Driver: apply one operand-read cycle and queue what must be seen
  task automatic cyc(int v, int sa, int ua, int sb, int ub, int d, int we,
                     int es, int esa, int esb, int eex, int ewb, int ewr, string req);
    expItem_t it;
    @(posedge clk);
    #5;
    orValid     = v[0];
    orSrc[0]    = sa[REG_W-1:0];
    orSrcUse[0] = ua[0];
    orSrc[1]    = sb[REG_W-1:0];
    orSrcUse[1] = ub[0];
    orDest      = d[REG_W-1:0];
    orDestWe    = we[0];
    it.s = es; it.sa = esa; it.sb = esb; it.ex = eex; it.wb = ewb; it.wr = ewr; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idle(int eex, int ewb, int ewr, string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, -1, -1, eex, ewb, ewr, req);
  endtask

  // Monitor: compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      chk(it.req, "stall", int'(stall), it.s);
      chk(it.req, "opSel[0]", int'(opSel[0]), it.sa);
      chk(it.req, "opSel[1]", int'(opSel[1]), it.sb);
      chk(it.req, "exLive", int'(exLive), it.ex);
      chk(it.req, "wbWrite", int'(wbWrite), it.wb);
      if (it.wb == 1) chk(it.req, "wbReg", int'(wbReg), it.wr);
    end
  end

  initial begin
    #(20 * MAX_CYC);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    // R1: clean state after reset
    idle(0, 0, -1, "R1");

    // R2: execute result needed on slot 0 (no bypass there)
    cyc(1, 2, 1, 3, 1, 1, 1,  0, -1, -1, 0, 0, -1, "R2");
    cyc(1, 1, 1, 4, 1, 5, 1,  1, -1, -1, 1, 0, -1, "R2");
    cyc(1, 1, 1, 4, 1, 5, 1,  0, 0, 0, 0, 1, 1, "R2 R7");
    idle(1, 0, -1, "R7");
    idle(0, 1, 5, "R8");

    // R3: same dependency on slot 1, which has the bypass
    cyc(1, 2, 1, 3, 1, 6, 1,  0, -1, -1, 0, 0, -1, "R3");
    cyc(1, 4, 1, 6, 1, 7, 1,  0, 0, 1, 1, 0, -1, "R3");
    idle(1, 1, 6, "R8");
    idle(0, 1, 7, "R8");

    // R4: producer in writeback during the read
    cyc(1, 2, 1, 3, 1, 8, 1,  0, -1, -1, 0, 0, -1, "R4");
    cyc(1, 2, 1, 3, 1, 10, 1, 0, -1, -1, 1, 0, -1, "R4");
    cyc(1, 8, 1, 10, 1, 11, 1, 0, 0, 1, 1, 1, 8, "R4 R3");
    idle(1, 1, 10, "R8");
    idle(0, 1, 11, "R8");

    // R5: register 0
    cyc(1, 2, 1, 3, 1, 0, 1,  0, -1, -1, 0, 0, -1, "R5");
    cyc(1, 0, 1, 0, 1, 0, 1,  0, 0, 0, 1, 0, -1, "R5");
    idle(1, 0, -1, "R5");
    idle(0, 0, -1, "R5");

    // R6: write-after-write
    cyc(1, 2, 1, 3, 1, 12, 1, 0, -1, -1, 0, 0, -1, "R6");
    cyc(1, 2, 1, 3, 1, 12, 1, 1, -1, -1, 1, 0, -1, "R6");
    cyc(1, 2, 1, 3, 1, 12, 1, 0, 0, 0, 0, 1, 12, "R6");
    idle(1, 0, -1, "R6");
    idle(0, 1, 12, "R6");

    // R10: unused source slot
    cyc(1, 2, 1, 3, 1, 13, 1, 0, -1, -1, 0, 0, -1, "R10");
    cyc(1, 13, 0, 2, 1, 14, 1, 0, 0, 0, 1, 0, -1, "R10");
    idle(1, 1, 13, "R10");
    idle(0, 1, 14, "R10");

    // R11: invalid slot with a pending dependency
    cyc(1, 2, 1, 3, 1, 15, 1, 0, -1, -1, 0, 0, -1, "R11");
    cyc(0, 15, 1, 15, 1, 16, 1, 0, -1, -1, 1, 0, -1, "R11");
    idle(0, 1, 15, "R11");

    // R9: bypass on both slots
    @(negedge clk); #1 cfgExBypass = 2'b11;
    cyc(1, 2, 1, 3, 1, 16, 1, 0, -1, -1, 0, 0, -1, "R9");
    cyc(1, 16, 1, 16, 1, 17, 1, 0, 1, 1, 1, 0, -1, "R9");
    idle(1, 1, 16, "R9");
    idle(0, 1, 17, "R9");

    // R9: no bypass anywhere
    @(negedge clk); #1 cfgExBypass = 2'b00;
    cyc(1, 2, 1, 3, 1, 18, 1, 0, -1, -1, 0, 0, -1, "R9");
    cyc(1, 2, 1, 18, 1, 19, 1, 1, -1, -1, 1, 0, -1, "R9");
    cyc(1, 2, 1, 18, 1, 19, 1, 0, 0, 0, 0, 1, 18, "R9 R2");
    idle(1, 0, -1, "R9");
    idle(0, 1, 19, "R9");

    @(negedge clk);
    #1;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule